// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This block executes the two atomic-pair instructions of a 64-bit RISC-V core: a load that places a reservation on its address, and a store that only takes effect while that reservation still holds. The pipeline hands it a 32-bit instruction word together with the two source operand values. The unit exposes the source register indices so a register file can supply those values. It decodes the word and, when the access is legal, runs one transfer on a simple synchronous memory port. The port carries a request, an address, a byte count, write data, a write enable and read data, and a ready signal ends each transfer.

Each accepted instruction ends with a one-cycle completion pulse. The pulse carries a destination value with its valid flag, or else an illegal-instruction flag or a misaligned-address flag. The unit holds one reservation, made of an address and an access size. A single input drops that reservation, so a coherence agent can invalidate it when another agent touches the line. The acquire and release ordering bits go to the memory port as sideband flags during the transfer and have no other effect.

Top module: `lrsc_unit`

## Requirements
- R1: An instruction decodes only when bits[6:0] = 0101111 and width bits[14:12] are 010 (word) or 011 (doubleword), with function bits[31:27] = 00010 for the reserved load (which also needs bits[24:20] = 0) or 00011 for the conditional store. Any other word completes with `illegal` set, makes no memory request and writes nothing back.
- R2: Bit 26 is acquire and bit 25 is release. A reserved load with release set, or a conditional store with acquire set, completes with `illegal`, makes no memory request and leaves the reservation unchanged.
- R3: The reserved load reads `mem_bytes` bytes at address rs1. For a word access the low 32 bits of `mem_rdata` are sign-extended to 64 bits. A doubleword result passes through unchanged. On completion the reservation takes that address and size.
- R4: The conditional store asserts `mem_we` with address rs1. A word store sends 4 bytes with `mem_wdata` = {32'b0, rs2[31:0]}. A doubleword store sends 8 bytes of the full rs2.
- R5: A conditional store succeeds only when a valid reservation matches both its address and its size. Success writes 0 to rd. Failure writes 1 to rd and makes no memory request.
- R6: Every conditional store that is not illegal clears the reservation, whether it succeeds or fails. Pulsing `resv_drop` high also clears it.
- R7: An address not aligned to its access size (4 or 8 bytes) completes with `misaligned` set. It makes no memory request, writes nothing back and clears the reservation.
- R8: When rd = 0, `wb_valid` stays low.
- R9: `busy` is high from the cycle after an accepted instruction until completion. `done` is a one-cycle pulse. A request holds its address and size stable until `mem_ready`.
- R10: `mem_acq` and `mem_rel` carry the instruction's acquire and release bits while the request is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered; accepted when not busy |
| instr | input | 32 | Instruction word |
| src1_idx | output | 5 | Address operand register index |
| src2_idx | output | 5 | Store data register index (0 for loads) |
| rs1_val | input | 64 | Address operand |
| rs2_val | input | 64 | Store data operand |
| resv_drop | input | 1 | Clears the reservation |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request address |
| mem_bytes | output | 4 | Bytes transferred (4 or 8) |
| mem_wdata | output | 64 | Write data |
| mem_acq | output | 1 | Acquire sideband |
| mem_rel | output | 1 | Release sideband |
| mem_rdata | input | 64 | Read data |
| mem_ready | input | 1 | Request completes this cycle |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Writeback valid |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value |
| illegal | output | 1 | Illegal instruction on completion |
| misaligned | output | 1 | Misaligned address on completion |

## Verification
The bench targets reservations that should no longer match. These are a second store after a successful one, a store whose size differs from the load's, a store to a neighbouring doubleword, an external drop, and a misaligned access placed between the pair. A design that compared only the address, or that forgot to clear on failure or on a misaligned access, would report success (rd = 0) and raise a write where the bench expects 1 and no request. Word loads read values with bit 31 set, so a zero-extending design returns the wrong upper half. Illegal encodings with the ordering bits swapped must raise no request, since a design that ignored them would run a transfer. Loads with rd = 0 must not assert writeback.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    localparam int XLEN = 64;
    localparam int ILEN = 32;
    localparam int RIDX = 5;
    localparam int BYTES_W = 4;

    localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
    localparam logic [4:0] FN_RESLOAD = 5'b00010;
    localparam logic [4:0] FN_CONDST  = 5'b00011;
    localparam logic [2:0] SZ_WORD    = 3'b010;
    localparam logic [2:0] SZ_DWORD   = 3'b011;

    typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_STORE} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RESP} state_e;

    typedef struct packed {
        op_e             op;
        logic            dword;
        logic            acq;
        logic            rel;
        logic [RIDX-1:0] rd;
        logic            bad;
    } dec_t;

    function automatic logic off_align(input logic [XLEN-1:0] a, input logic dw);
        return dw ? (a[2:0] != 3'd0) : (a[1:0] != 2'd0);
    endfunction

    function automatic logic [XLEN-1:0] sext_word(input logic [XLEN-1:0] v);
        return {{(XLEN-32){v[31]}}, v[31:0]};
    endfunction

    function automatic logic [BYTES_W-1:0] byte_count(input logic dw);
        return dw ? BYTES_W'(8) : BYTES_W'(4);
    endfunction
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec,
    output logic [RIDX-1:0] src1_idx,
    output logic [RIDX-1:0] src2_idx
);
    logic fmt_ok, is_ld, is_st;

    always_comb begin
        fmt_ok = (instr[6:0] == OPC_ATOMIC) &&
                 ((instr[14:12] == SZ_WORD) || (instr[14:12] == SZ_DWORD));
        is_ld  = fmt_ok && (instr[31:27] == FN_RESLOAD) && (instr[24:20] == '0);
        is_st  = fmt_ok && (instr[31:27] == FN_CONDST);

        dec.op    = is_ld ? OP_LOAD : (is_st ? OP_STORE : OP_NONE);
        dec.dword = instr[12];
        dec.acq   = instr[26];
        dec.rel   = instr[25];
        dec.rd    = instr[11:7];
        dec.bad   = !(is_ld || is_st) || (is_ld && instr[25]) || (is_st && instr[26]);

        src1_idx  = instr[19:15];
        src2_idx  = is_ld ? '0 : instr[24:20];
    end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
    import lrsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic            clr,
    input  logic            ext_clr,
    input  logic [XLEN-1:0] set_addr,
    input  logic            set_dw,
    input  logic [XLEN-1:0] chk_addr,
    input  logic            chk_dw,
    output logic            hit
);
    logic            v_q;
    logic [XLEN-1:0] a_q;
    logic            dw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q  <= 1'b0;
            a_q  <= '0;
            dw_q <= 1'b0;
        end else if (set) begin
            v_q  <= 1'b1;
            a_q  <= set_addr;
            dw_q <= set_dw;
        end else if (clr || ext_clr) begin
            v_q  <= 1'b0;
        end
    end

    assign hit = v_q && (a_q == chk_addr) && (dw_q == chk_dw);
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
    import lrsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  dec_t               dec,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [XLEN-1:0]    rs2_val,
    input  logic               resv_hit,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_ready,
    output logic               resv_set,
    output logic               resv_clr,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [BYTES_W-1:0] mem_bytes,
    output logic [XLEN-1:0]    mem_wdata,
    output logic               mem_acq,
    output logic               mem_rel,
    output logic               done,
    output logic               wb_valid,
    output logic [RIDX-1:0]    wb_rd,
    output logic [XLEN-1:0]    wb_data,
    output logic               illegal,
    output logic               misaligned
);
    state_e          st_q;
    op_e             op_q;
    logic            dw_q, acq_q, rel_q;
    logic [RIDX-1:0] rd_q;
    logic [XLEN-1:0] addr_q, wdata_q, res_q;
    logic            wbv_q, ill_q, mis_q;

    logic accept, mis_now, xfer_end;

    always_comb begin
        accept   = (st_q == ST_IDLE) && instr_valid;
        mis_now  = off_align(rs1_val, dec.dword);
        xfer_end = (st_q == ST_XFER) && mem_ready;
        resv_set = xfer_end && (op_q == OP_LOAD);
        resv_clr = accept && !dec.bad && (mis_now || (dec.op == OP_STORE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= OP_NONE;
            dw_q    <= 1'b0;
            acq_q   <= 1'b0;
            rel_q   <= 1'b0;
            rd_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
            wbv_q   <= 1'b0;
            ill_q   <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    op_q    <= dec.op;
                    dw_q    <= dec.dword;
                    acq_q   <= dec.acq;
                    rel_q   <= dec.rel;
                    rd_q    <= dec.rd;
                    addr_q  <= rs1_val;
                    wdata_q <= dec.dword ? rs2_val : {{(XLEN-32){1'b0}}, rs2_val[31:0]};
                    wbv_q   <= 1'b0;
                    ill_q   <= 1'b0;
                    mis_q   <= 1'b0;
                    res_q   <= '0;
                    if (dec.bad) begin
                        ill_q <= 1'b1;
                        st_q  <= ST_RESP;
                    end else if (mis_now) begin
                        mis_q <= 1'b1;
                        st_q  <= ST_RESP;
                    end else if ((dec.op == OP_STORE) && !resv_hit) begin
                        wbv_q <= (dec.rd != '0);
                        res_q <= XLEN'(1);
                        st_q  <= ST_RESP;
                    end else begin
                        st_q  <= ST_XFER;
                    end
                end
                ST_XFER: if (mem_ready) begin
                    wbv_q <= (rd_q != '0);
                    if (op_q == OP_LOAD)
                        res_q <= dw_q ? mem_rdata : sext_word(mem_rdata);
                    else
                        res_q <= '0;
                    st_q  <= ST_RESP;
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st_q != ST_IDLE);
        mem_req    = (st_q == ST_XFER);
        mem_we     = mem_req && (op_q == OP_STORE);
        mem_addr   = addr_q;
        mem_bytes  = byte_count(dw_q);
        mem_wdata  = wdata_q;
        mem_acq    = mem_req && acq_q;
        mem_rel    = mem_req && rel_q;
        done       = (st_q == ST_RESP);
        wb_valid   = done && wbv_q;
        wb_rd      = rd_q;
        wb_data    = res_q;
        illegal    = done && ill_q;
        misaligned = done && mis_q;
    end
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [ILEN-1:0]    instr,
    output logic [RIDX-1:0]    src1_idx,
    output logic [RIDX-1:0]    src2_idx,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [XLEN-1:0]    rs2_val,
    input  logic               resv_drop,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [BYTES_W-1:0] mem_bytes,
    output logic [XLEN-1:0]    mem_wdata,
    output logic               mem_acq,
    output logic               mem_rel,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_ready,
    output logic               done,
    output logic               wb_valid,
    output logic [RIDX-1:0]    wb_rd,
    output logic [XLEN-1:0]    wb_data,
    output logic               illegal,
    output logic               misaligned
);
    dec_t dec;
    logic hit, rset, rclr;

    lrsc_decode u_dec (
        .instr    (instr),
        .dec      (dec),
        .src1_idx (src1_idx),
        .src2_idx (src2_idx)
    );

    lrsc_resv u_resv (
        .clk      (clk),
        .rst      (rst),
        .set      (rset),
        .clr      (rclr),
        .ext_clr  (resv_drop),
        .set_addr (mem_addr),
        .set_dw   (mem_bytes == BYTES_W'(8)),
        .chk_addr (rs1_val),
        .chk_dw   (dec.dword),
        .hit      (hit)
    );

    lrsc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .dec         (dec),
        .rs1_val     (rs1_val),
        .rs2_val     (rs2_val),
        .resv_hit    (hit),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .resv_set    (rset),
        .resv_clr    (rclr),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_bytes   (mem_bytes),
        .mem_wdata   (mem_wdata),
        .mem_acq     (mem_acq),
        .mem_rel     (mem_rel),
        .done        (done),
        .wb_valid    (wb_valid),
        .wb_rd       (wb_rd),
        .wb_data     (wb_data),
        .illegal     (illegal),
        .misaligned  (misaligned)
    );
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk
    import lrsc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic [XLEN-1:0]    mem_addr,
    input logic [BYTES_W-1:0] mem_bytes,
    input logic               wb_valid,
    input logic [RIDX-1:0]    wb_rd,
    input logic               illegal,
    input logic               misaligned
);
    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_req); // R5
    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst) (illegal || misaligned) |-> !wb_valid); // R1
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(illegal && misaligned)); // R2
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_bytes == BYTES_W'(8)) ? (mem_addr[2:0] == 3'd0)
                    : ((mem_bytes == BYTES_W'(4)) && (mem_addr[1:0] == 2'd0)))); // R7
    AST_NO_X0_WB: assert property (@(posedge clk) disable iff (rst) wb_valid |-> (wb_rd != '0)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_bytes))); // R9
    AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (rst) (wb_valid || illegal || misaligned) |-> done); // R9
endmodule

bind lrsc_unit lrsc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_bytes  (mem_bytes),
    .wb_valid   (wb_valid),
    .wb_rd      (wb_rd),
    .illegal    (illegal),
    .misaligned (misaligned)
);

// File: tb/lrsc_unit_test.sv
module lrsc_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  src1_idx, src2_idx;
    logic [63:0] rs1_val = '0, rs2_val = '0;
    logic        resv_drop = 1'b0;
    logic        busy, mem_req, mem_we, mem_acq, mem_rel;
    logic [63:0] mem_addr, mem_wdata;
    logic [3:0]  mem_bytes;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done, wb_valid, illegal, misaligned;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data;

    int total = 0;
    int bad = 0;

    logic        m_v = 1'b0;
    logic [63:0] m_a = '0;
    logic        m_dw = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .src1_idx(src1_idx), .src2_idx(src2_idx),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .resv_drop(resv_drop),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_wdata(mem_wdata), .mem_acq(mem_acq),
        .mem_rel(mem_rel), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
        .illegal(illegal), .misaligned(misaligned)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] fn, input logic aq, input logic rl,
                                        input logic [4:0] r2, input logic [4:0] r1,
                                        input logic [2:0] w, input logic [4:0] rd,
                                        input logic [6:0] opc);
        return {fn, aq, rl, r2, r1, w, rd, opc};
    endfunction

    function automatic logic [31:0] lr_i(input logic dw, input logic aq, input logic rl, input logic [4:0] rd);
        return enc(5'b00010, aq, rl, 5'd0, 5'd3, dw ? 3'b011 : 3'b010, rd, 7'b0101111);
    endfunction

    function automatic logic [31:0] sc_i(input logic dw, input logic aq, input logic rl, input logic [4:0] rd);
        return enc(5'b00011, aq, rl, 5'd6, 5'd3, dw ? 3'b011 : 3'b010, rd, 7'b0101111);
    endfunction

    task automatic drop_resv();
        @(negedge clk);
        resv_drop = 1'b1;
        @(negedge clk);
        resv_drop = 1'b0;
        m_v = 1'b0;
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] d,
                       input logic [63:0] rdat, input int delay);
        logic fmt, ld, st, dw, ill, mis, hit, mem, wbv;
        logic [63:0] wbd, ewd;
        string ri, rm;
        bit saw, got;
        int waited;
        fmt = (ins[6:0] == 7'b0101111) && ((ins[14:12] == 3'b010) || (ins[14:12] == 3'b011));
        ld  = fmt && (ins[31:27] == 5'b00010) && (ins[24:20] == 5'd0);
        st  = fmt && (ins[31:27] == 5'b00011);
        dw  = (ins[14:12] == 3'b011);
        ill = !(ld || st) || (ld && ins[25]) || (st && ins[26]);
        ri  = ((ld && ins[25]) || (st && ins[26])) ? "R2" : "R1";
        mis = !ill && (dw ? (a[2:0] != 0) : (a[1:0] != 0));
        hit = m_v && (m_a == a) && (m_dw == dw);
        mem = !ill && !mis && (ld || hit);
        wbv = !ill && !mis && (ins[11:7] != 0);
        wbd = ld ? (dw ? rdat : {{32{rdat[31]}}, rdat[31:0]}) : (hit ? 64'd0 : 64'd1);
        ewd = dw ? d : {32'd0, d[31:0]};
        rm  = ill ? ri : (mis ? "R7" : "R5 R6");
        if (!ill && (mis || st)) m_v = 1'b0;
        if (mem && ld) begin m_v = 1'b1; m_a = a; m_dw = dw; end

        @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = d; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
        saw = 0; got = 0; waited = 0;
        for (int k = 0; k < 60; k++) begin
            if (done) begin got = 1; break; end
            if (mem_req) begin
                if (!saw) begin
                    chk(mem_addr === a, "R4", "mem_addr", mem_addr, a);
                    chk(mem_bytes === (dw ? 4'd8 : 4'd4), "R4", "mem_bytes", 64'(mem_bytes), dw ? 64'd8 : 64'd4);
                    chk(mem_we === st, "R4", "mem_we", 64'(mem_we), 64'(st));
                    if (st) chk(mem_wdata === ewd, "R4", "mem_wdata", mem_wdata, ewd);
                    chk({mem_acq, mem_rel} === ins[26:25], "R10", "acq/rel sideband",
                        64'({mem_acq, mem_rel}), 64'(ins[26:25]));
                end
                saw = 1;
                if (waited >= delay) begin mem_ready = 1'b1; mem_rdata = rdat; end
                else waited++;
            end
            @(negedge clk);
            mem_ready = 1'b0;
        end
        chk(got, "R9", "completion pulse", 64'(got), 64'd1);
        chk(saw == mem, rm, "memory request made", 64'(saw), 64'(mem));
        chk(illegal === ill, ri, "illegal flag", 64'(illegal), 64'(ill));
        chk(misaligned === mis, "R7", "misaligned flag", 64'(misaligned), 64'(mis));
        chk(wb_valid === wbv, "R8", "wb_valid", 64'(wb_valid), 64'(wbv));
        if (wbv) begin
            chk(wb_rd === ins[11:7], "R8", "wb_rd", 64'(wb_rd), 64'(ins[11:7]));
            chk(wb_data === wbd, ld ? "R3" : "R5 R6", "wb_data", wb_data, wbd);
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9", "done one cycle then idle", 64'({done, busy}), 64'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog: actual=%h expected=%h", 64'd1, 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, mem_req, wb_valid} === 4'd0, "R9", "reset state", 64'({busy, done, mem_req, wb_valid}), 64'd0);

        // R5: store with no reservation fails
        run(sc_i(0, 0, 0, 5'd7), 64'h100, 64'h1, 64'h0, 0);
        // R3 R4 R5: word pair, negative word
        run(lr_i(0, 0, 0, 5'd8), 64'h100, 64'h0, 64'hDEAD_BEEF_8000_1234, 2);
        run(sc_i(0, 0, 0, 5'd9), 64'h100, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 1);
        // R6: second store after success fails
        run(sc_i(0, 0, 0, 5'd9), 64'h100, 64'h5, 64'h0, 0);
        // R5: size mismatch
        run(lr_i(1, 0, 0, 5'd10), 64'h208, 64'h0, 64'h1234_5678_9ABC_DEF0, 0);
        run(sc_i(0, 0, 0, 5'd11), 64'h208, 64'h7, 64'h0, 0);
        // R6: external drop
        run(lr_i(1, 0, 0, 5'd10), 64'h300, 64'h0, 64'h8000_0000_0000_0001, 3);
        drop_resv();
        run(sc_i(1, 0, 0, 5'd11), 64'h300, 64'h7, 64'h0, 0);
        // R5: address mismatch
        run(lr_i(1, 0, 0, 5'd10), 64'h300, 64'h0, 64'h42, 0);
        run(sc_i(1, 0, 0, 5'd11), 64'h308, 64'h7, 64'h0, 0);
        // R2: unsupported ordering combinations, reservation kept
        run(lr_i(1, 0, 0, 5'd12), 64'h500, 64'h0, 64'h99, 0);
        run(lr_i(1, 0, 1, 5'd12), 64'h500, 64'h0, 64'h99, 0);
        run(sc_i(1, 1, 0, 5'd12), 64'h500, 64'h3, 64'h0, 0);
        run(sc_i(1, 0, 1, 5'd13), 64'h500, 64'h1234, 64'h0, 0);
        // R1: malformed encodings
        run(enc(5'b00010, 0, 0, 5'd0, 5'd3, 3'b010, 5'd4, 7'b0101011), 64'h0, 64'h0, 64'h0, 0);
        run(enc(5'b00010, 0, 0, 5'd0, 5'd3, 3'b001, 5'd4, 7'b0101111), 64'h0, 64'h0, 64'h0, 0);
        run(enc(5'b00010, 0, 0, 5'd2, 5'd3, 3'b010, 5'd4, 7'b0101111), 64'h0, 64'h0, 64'h0, 0);
        run(enc(5'b00001, 0, 0, 5'd2, 5'd3, 3'b011, 5'd4, 7'b0101111), 64'h0, 64'h0, 64'h0, 0);
        // R7: misaligned clears reservation
        run(lr_i(0, 0, 0, 5'd14), 64'h400, 64'h0, 64'h7FFF_FFFF, 0);
        run(lr_i(0, 0, 0, 5'd14), 64'h405, 64'h0, 64'h1, 0);
        run(sc_i(0, 0, 0, 5'd15), 64'h400, 64'h1, 64'h0, 0);
        run(lr_i(1, 0, 0, 5'd14), 64'h404, 64'h0, 64'h1, 0);
        // R8: rd = 0; R10: acquire on load
        run(lr_i(0, 1, 0, 5'd0), 64'h600, 64'h0, 64'hFFFF_FFFF, 1);
        run(sc_i(0, 0, 1, 5'd0), 64'h600, 64'h9, 64'h0, 0);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [4:0] fn; logic [2:0] w; logic [4:0] r2; logic [63:0] a;
            logic [6:0] opc;
            fn  = ($urandom_range(0, 9) < 9) ? ($urandom_range(0, 1) ? 5'b00011 : 5'b00010) : 5'($urandom);
            w   = ($urandom_range(0, 7) < 7) ? ($urandom_range(0, 1) ? 3'b011 : 3'b010) : 3'($urandom);
            r2  = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0;
            opc = ($urandom_range(0, 15) == 0) ? 7'($urandom) : 7'b0101111;
            a   = 64'h1000 + 64'($urandom_range(0, 3) * 8);
            if ($urandom_range(0, 9) == 0) a = a + 64'($urandom_range(1, 7));
            else if ($urandom_range(0, 4) == 0) a = a + 64'd4;
            if ($urandom_range(0, 19) == 0) drop_resv();
            run(enc(fn, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), r2, 5'd3, w,
                    ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31)), opc),
                a, {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 3));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule